// File: doc/BRIEF.md
# Burst Acquisition Sync Controller

This block schedules measurement bursts for one sensing node in a chain of such nodes. Between bursts the node sleeps. A burst begins either when an upstream node sends an active-low pulse on the sync input, or when the node's own sleep period runs out. When the burst ends, the node drives an active-low pulse on its sync output, so that the next node in the chain can start its own burst. The measurement engine itself is outside the block. It receives a one-cycle start strobe and returns a one-cycle done signal.

The sleep period is the 4-bit setting multiplied by `BASE_TICKS` clock cycles. The timer reloads on every burst start. Low glitches on the sync input that are shorter than `MIN_PULSE` cycles do not count as a pulse.

A qualified pulse that arrives during a burst, or while the node is waiting after a burst, is discarded. After a burst the node stays awake for as long as the sync input is held low.

In fast-integration mode, bursts follow one another back to back. Only the last burst of such a series produces a downstream pulse. A sleep setting of zero suppresses the sync output entirely. If the sync input is tied high, the node runs freely at its timer rate.

In a chain, the node with the shortest sleep setting acts as the master. In a closed loop, the master restarts the chain when the last node's pulse comes back to it, or on its own timeout if no pulse arrives.

Top module: `burst_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, `burst_start` is 0 and `sync_out_n` is 1. The first `burst_start` strobe appears on the third rising clock edge after `rst_n` rises.
- R2: While sleeping with no qualified sync pulse, a burst starts exactly `sleep_cfg*BASE_TICKS` cycles after the previous start, provided the preceding burst has completed by then. The timer reloads at every start, including fast-integration restarts.
- R3: While sleeping, a low level on `sync_in_n` lasting at least `MIN_PULSE` consecutive cycles starts a burst. The strobe appears `MIN_PULSE+2` cycles after the input falls. A low lasting fewer than `MIN_PULSE` cycles is ignored.
- R4: `burst_start` is a single-cycle high strobe. It follows either a sleeping-state trigger or a fast-integration `burst_done`.
- R5: A `burst_done` taken with `fast_req` low and `sleep_cfg` non-zero drives `sync_out_n` low for exactly `SYNC_OUT_W` cycles, starting on the next cycle.
- R6: If the synchronized sync input is low when `burst_done` is taken, the node waits and does not start a burst until the input is high again. If the timer has already expired, the start strobe appears 4 cycles after `sync_in_n` rises.
- R7: A qualified sync pulse that completes during a burst or during the post-burst wait does not start a burst.
- R8: A `burst_done` taken with `fast_req` high restarts a burst on the next cycle and produces no `sync_out_n` pulse.
- R9: When `sleep_cfg` is 0, no `sync_out_n` pulse is produced. The node restarts 2 cycles after `burst_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in_n | input | 1 | Active-low sync pulse from the upstream node (asynchronous) |
| sleep_cfg | input | CFG_W | Sleep setting, in units of BASE_TICKS cycles |
| fast_req | input | 1 | Fast-integration request: the next burst follows immediately |
| burst_done | input | 1 | One-cycle completion from the measurement engine |
| burst_start | output | 1 | One-cycle burst start strobe |
| sync_out_n | output | 1 | Active-low sync pulse to the downstream node |

## Verification
The hardest case to reach is the post-burst wait. To reach it, the sync input must go low during a burst, stay low through `burst_done`, and still be low after the sleep timer has expired. Only then does releasing it show both the block on restarts and the immediate restart that follows. The stimulus drives the line low one cycle into a burst and holds it for well past the sleep period. It then predicts the start strobe at the synchronizer delay plus two state updates after the release. A second case is a qualified pulse that completes inside a burst. This is placed by timing the pulse against the known start cycle, and the check is that the next start comes only from the timer.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_BURST = 2'd1,
    ST_HOLD  = 2'd2
  } bsc_state_e;
endpackage

// File: rtl/bsc_sync_qual.sv
// Synchronizes the asynchronous sync line and qualifies low pulses by width.
module bsc_sync_qual #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned MIN_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in_n,
  output logic hit,
  output logic line_low
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 1);

  logic [STAGES-1:0] pipe_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b1;
          else        pipe_q[0] <= sync_in_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[gi] <= 1'b1;
          else        pipe_q[gi] <= pipe_q[gi-1];
        end
      end
    end
  endgenerate

  assign line_low = ~pipe_q[STAGES-1];

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!line_low) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CW'(MIN_PULSE)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = line_low && (cnt_q == CW'(MIN_PULSE - 1));
endmodule

// File: rtl/bsc_sleep_timer.sv
// Down-counter loaded with the sleep period at every burst start.
module bsc_sleep_timer #(
  parameter int unsigned BASE_TICKS = 1000,
  parameter int unsigned CFG_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  output logic             expired
);
  localparam int unsigned MAX_PERIOD = ((1 << CFG_W) - 1) * BASE_TICKS;
  localparam int unsigned TW         = $clog2(MAX_PERIOD + 1);

  logic [TW-1:0] period;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign period = TW'(cfg) * TW'(BASE_TICKS);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (period == '0) ? '0 : period - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bsc_pulse_out.sv
// Fixed-width active-low output pulse, retriggered by fire.
module bsc_pulse_out #(
  parameter int unsigned WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int unsigned PW = $clog2(WIDTH + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (fire) begin
      cnt_en = 1'b1;
      cnt_d  = PW'(WIDTH);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/burst_sync_ctrl.sv
module burst_sync_ctrl
  import bsc_pkg::*;
#(
  parameter int unsigned BASE_TICKS  = 1000,
  parameter int unsigned MIN_PULSE   = 16,
  parameter int unsigned SYNC_OUT_W  = 32,
  parameter int unsigned CFG_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in_n,
  input  logic [CFG_W-1:0] sleep_cfg,
  input  logic             fast_req,
  input  logic             burst_done,
  output logic             burst_start,
  output logic             sync_out_n
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic       sync_hit, line_low, expired;
  logic       start_now, fire_sync;
  bsc_state_e state_q, state_d;
  logic       start_q;

  bsc_sync_qual #(.STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sync_in_n(sync_in_n),
    .hit      (sync_hit),
    .line_low (line_low)
  );

  bsc_sleep_timer #(.BASE_TICKS(BASE_TICKS), .CFG_W(CFG_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load   (start_now),
    .cfg    (sleep_cfg),
    .expired(expired)
  );

  bsc_pulse_out #(.WIDTH(SYNC_OUT_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .fire   (fire_sync),
    .pulse_n(sync_out_n)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    start_now = 1'b0;
    fire_sync = 1'b0;
    unique case (state_q)
      ST_SLEEP: begin
        if (sync_hit || expired) begin
          start_now = 1'b1;
          state_d   = ST_BURST;
        end
      end
      ST_BURST: begin
        if (burst_done) begin
          if (fast_req) begin
            start_now = 1'b1;
          end else begin
            fire_sync = (sleep_cfg != '0);
            state_d   = line_low ? ST_HOLD : ST_SLEEP;
          end
        end
      end
      ST_HOLD: begin
        if (!line_low) state_d = ST_SLEEP;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  // state and strobe registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_SLEEP;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_now;
    end
  end

  assign burst_start = start_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
  import bsc_pkg::*;
#(
  parameter int unsigned CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_core_n,
  input logic             burst_start,
  input logic             sync_out_n,
  input logic             burst_done,
  input logic             fast_req,
  input logic [CFG_W-1:0] sleep_cfg,
  input bsc_state_e       st,
  input logic             hit,
  input logic             line_low
);
  a_r1_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> (!burst_start && sync_out_n));

  a_r3_sync_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st == ST_SLEEP) |=> burst_start);

  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> ($past(st) == ST_SLEEP || ($past(burst_done) && $past(fast_req))));

  a_r5_sync_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out_n) |-> ($past(burst_done) && !$past(fast_req)
                           && $past(sleep_cfg) != '0 && $past(st) == ST_BURST));

  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && line_low) |=> (st == ST_HOLD && !burst_start));

  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st != ST_SLEEP && !(burst_done && fast_req)) |=> !burst_start);

  a_r8_fast_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BURST && burst_done && fast_req) |=> (burst_start && st == ST_BURST));
endmodule

bind burst_sync_ctrl bsc_checker #(.CFG_W(CFG_W)) u_bsc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .burst_start(burst_start),
  .sync_out_n (sync_out_n),
  .burst_done (burst_done),
  .fast_req   (fast_req),
  .sleep_cfg  (sleep_cfg),
  .st         (state_q),
  .hit        (sync_hit),
  .line_low   (line_low)
);

// File: tb/tb_burst_sync_ctrl.sv
module tb_burst_sync_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 8;
  localparam int MINP       = 4;
  localparam int OUTW       = 3;
  localparam int EV_START   = 0;
  localparam int EV_FALL    = 1;
  localparam int EV_RISE    = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in_n;
  logic [3:0] sleep_cfg;
  logic       fast_req;
  logic       burst_done;
  logic       burst_start;
  logic       sync_out_n;

  burst_sync_ctrl #(.BASE_TICKS(BASE), .MIN_PULSE(MINP), .SYNC_OUT_W(OUTW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in_n(sync_in_n), .sleep_cfg(sleep_cfg),
    .fast_req(fast_req), .burst_done(burst_done), .burst_start(burst_start),
    .sync_out_n(sync_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t  q[$];
  int    ncyc = 0;
  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    so_prev = 1'b1;
  bit    finished = 1'b0;

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic check(string req, bit ok, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_to(int k);
    while (ncyc < k) @(negedge clk);
  endtask

  task automatic pulse_done(int k);
    wait_to(k);
    burst_done = 1'b1;
    wait_to(k + 1);
    burst_done = 1'b0;
  endtask

  task automatic sync_low(int k, int len);
    wait_to(k);
    sync_in_n = 1'b0;
    wait_to(k + len);
    sync_in_n = 1'b1;
  endtask

  // monitor: pops the scoreboard as events appear
  task automatic match(int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(phase, 1'b0, kind, -1, $sformatf("unexpected event at cycle %0d", ncyc));
    end else begin
      e = q.pop_front();
      check(e.req, e.kind == kind, kind, e.kind, "event kind");
      check(e.req, e.at == ncyc, ncyc, e.at, "event cycle");
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (burst_start) match(EV_START);
      if (so_prev && !sync_out_n) match(EV_FALL);
      if (!so_prev && sync_out_n) match(EV_RISE);
    end
    so_prev = sync_out_n;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", ncyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b;
    int k0;
    rst_n = 1'b0; sync_in_n = 1'b1; sleep_cfg = 4'd4; fast_req = 1'b0; burst_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", burst_start == 1'b0, burst_start, 0, "start in reset");
    check("R1", sync_out_n == 1'b1, sync_out_n, 1, "sync_out in reset");
    rst_n = 1'b1;
    k0 = ncyc;
    b = k0 + 3;
    expect_ev(EV_START, b, "R1 first start");
    wait_to(k0 + 2);
    check("R1", burst_start == 1'b0, burst_start, 0, "start before release");

    // timer-driven runs with sync held high
    phase = "R2";
    expect_ev(EV_FALL, b + 6, "R5 fall");
    expect_ev(EV_RISE, b + 6 + OUTW, "R5 width");
    expect_ev(EV_START, b + 32, "R2 timeout");
    pulse_done(b + 5);
    b = b + 32;
    expect_ev(EV_FALL, b + 6, "R5 fall");
    expect_ev(EV_RISE, b + 6 + OUTW, "R5 width");
    expect_ev(EV_START, b + 32, "R2 timeout");
    pulse_done(b + 5);
    b = b + 32;

    // glitch ignored, valid pulse starts
    phase = "R3";
    expect_ev(EV_FALL, b + 6, "R5 fall");
    expect_ev(EV_RISE, b + 6 + OUTW, "R5 width");
    pulse_done(b + 5);
    sync_low(b + 8, MINP - 1);
    expect_ev(EV_START, b + 14 + MINP + 2, "R3 sync start");
    sync_low(b + 14, MINP);
    b = b + 14 + MINP + 2;

    // qualified pulse inside a burst is dropped
    phase = "R7";
    expect_ev(EV_FALL, b + 13, "R5 fall");
    expect_ev(EV_RISE, b + 13 + OUTW, "R5 width");
    expect_ev(EV_START, b + 32, "R7 start only by timer");
    sync_low(b + 2, MINP);
    pulse_done(b + 12);
    b = b + 32;

    // sync still low at done: wait past timeout
    phase = "R6";
    expect_ev(EV_FALL, b + 7, "R5 fall");
    expect_ev(EV_RISE, b + 7 + OUTW, "R5 width");
    wait_to(b + 1);
    sync_in_n = 1'b0;
    pulse_done(b + 6);
    wait_to(b + 40);
    expect_ev(EV_START, b + 44, "R6 start after release");
    sync_in_n = 1'b1;
    b = b + 44;

    // fast integration series
    phase = "R8";
    wait_to(b + 1);
    fast_req = 1'b1;
    expect_ev(EV_START, b + 5, "R8 fast restart");
    pulse_done(b + 4);
    expect_ev(EV_START, b + 9, "R8 fast restart");
    pulse_done(b + 8);
    wait_to(b + 10);
    fast_req = 1'b0;
    expect_ev(EV_FALL, b + 13, "R8 single pulse after series");
    expect_ev(EV_RISE, b + 13 + OUTW, "R5 width");
    pulse_done(b + 12);
    wait_to(b + 20);
    sleep_cfg = 4'd0;
    expect_ev(EV_START, b + 41, "R2 reload at fast start");
    b = b + 41;

    // zero sleep setting
    phase = "R9";
    expect_ev(EV_START, b + 6, "R9 restart");
    pulse_done(b + 4);
    expect_ev(EV_START, b + 11, "R9 restart");
    pulse_done(b + 9);
    wait_to(b + 12);
    check("R9", q.size() == 0, q.size(), 0, "pending events");
    check("R9", sync_out_n == 1'b1, sync_out_n, 1, "sync_out idle");
    sleep_cfg = 4'd4;
    phase = "R5";
    expect_ev(EV_FALL, b + 15, "R5 fall");
    expect_ev(EV_START, b + 16, "R4 start");
    expect_ev(EV_RISE, b + 15 + OUTW, "R5 width");
    pulse_done(b + 14);
    b = b + 16;
    expect_ev(EV_FALL, b + 4, "R5 fall");
    expect_ev(EV_RISE, b + 4 + OUTW, "R5 width");
    pulse_done(b + 3);
    wait_to(b + 20);
    check("R4", q.size() == 0, q.size(), 0, "pending events at end");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule